// File: doc/BRIEF.md
# Segmented Memory Bank Mapper

This block sits between a CPU with a 16-bit address bus and a larger paged memory. The top two address bits pick one of four 16 KB windows. Each window has its own mapping register. For every CPU address the block gives the physical bank and the in-bank offset twice: once for the read path and once for the write path. The memory system can then serve a read and a write from different banks within the same window.

Software loads a window register by writing one byte to that window's I/O port.

- If bit 7 of the byte is set, the byte names one bank, up to 128 banks, used for both reads and writes.
- If bit 7 is clear, the byte holds two 3-bit bank numbers, one for reads and one for writes. Split mapping can therefore only reach the first eight banks.

A separate override port holds one bit per window. A set bit makes that window's reads follow its write bank. This lets a split mapping be collapsed without rewriting the window register. The mapping outputs are purely combinational from the registers and the CPU address.

Top module: `bankmap_top`

## Requirements
- R1: The window is selected by `cpu_addr[15:14]`. Both `rd_offset` and `wr_offset` equal `cpu_addr[13:0]`.
- R2: A port byte with bit 7 = 1 sets that window's read bank and write bank both to bits 6..0 of the byte (0x85 gives bank 5; 0xFF gives bank 127).
- R3: A port byte with bit 7 = 0 sets the write bank to bits 2..0 and the read bank to bits 6..4, with the upper bank bits zero. Bit 3 is ignored.
- R4: I/O addresses 0xF0, 0xF1, 0xF2 and 0xF3 load the windows at 0x0000, 0x4000, 0x8000 and 0xC000 respectively. A write to any other address, other than the override port, changes no mapping.
- R5: The override port is at address 0xF4. Its bits 7, 6, 5 and 4, when set, make reads use the write bank in the windows at 0xC000, 0x0000, 0x8000 and 0x4000 respectively. Bits 3..0 have no effect.
- R6: While `rst_n` is low at a clock edge, the windows are set to unified banks 0, 1, 2 and 3 (lowest window first), and all override bits are cleared.
- R7: A port write takes effect at the rising clock edge where `io_wr` is sampled high. Before that edge the old mapping is still shown. With `io_wr` low, no register changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_wr | input | 1 | I/O write strobe, sampled on the rising edge |
| io_addr | input | 8 | I/O port address |
| io_data | input | 8 | I/O write data |
| cpu_addr | input | 16 | CPU memory address |
| rd_bank | output | 7 | Physical bank for a read at `cpu_addr` |
| rd_offset | output | 14 | In-bank offset for the read path |
| wr_bank | output | 7 | Physical bank for a write at `cpu_addr` |
| wr_offset | output | 14 | In-bank offset for the write path |

## Verification
The bench goes after the bit 7 mode split with bytes that differ only in bit 7. A decoder that took the wrong mode would then show a 7-bit bank where two 3-bit fields were expected, or the reverse. It puts a different split mapping in every window and sets one override bit at a time. A crossed override bit order then shows up as a read bank that collapses in the wrong window.

It also writes to neighbouring I/O addresses, holds a matching address with the strobe low, and sets bit 3 in split bytes and the low override nibble. An incomplete decode would visibly change a bank. A mapper that went combinational on the strobe would show the new bank one cycle early, and the bench checks the old bank inside the write cycle to catch this.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;

    localparam int ADDR_W    = 16;
    localparam int SEG_CNT   = 4;
    localparam int SEL_W     = $clog2(SEG_CNT);
    localparam int OFS_W     = ADDR_W - SEL_W;
    localparam int BANK_W    = 7;
    localparam int SPLIT_W   = 3;
    localparam int BYTE_W    = 8;
    localparam int MODE_BIT  = BYTE_W - 1;
    localparam int RD_LSB    = 4;

    typedef struct packed {
        logic [BANK_W-1:0] rd;
        logic [BANK_W-1:0] wr;
    } seg_map_t;

    typedef seg_map_t [SEG_CNT-1:0] seg_arr_t;

    // Turn one port byte into a read/write bank pair.
    function automatic seg_map_t decode_byte(input logic [BYTE_W-1:0] b);
        seg_map_t m;
        if (b[MODE_BIT]) begin
            m.rd = b[BANK_W-1:0];
            m.wr = b[BANK_W-1:0];
        end else begin
            m.rd = BANK_W'(b[RD_LSB +: SPLIT_W]);
            m.wr = BANK_W'(b[SPLIT_W-1:0]);
        end
        return m;
    endfunction

    // Bit of the override byte that governs a given window.
    function automatic int override_bit(input int seg);
        case (seg)
            0:       return 6;
            1:       return 4;
            2:       return 5;
            default: return 7;
        endcase
    endfunction

    // Mapping applied on reset: window n holds unified bank n.
    function automatic seg_arr_t reset_map();
        seg_arr_t a;
        for (int s = 0; s < SEG_CNT; s++) begin
            a[s].rd = BANK_W'(s);
            a[s].wr = BANK_W'(s);
        end
        return a;
    endfunction

endpackage

// File: rtl/bankmap_port_dec.sv
module bankmap_port_dec
    import bankmap_pkg::*;
#(
    parameter logic [BYTE_W-1:0] SEG_PORT_BASE = 8'hF0,
    parameter logic [BYTE_W-1:0] OVR_PORT      = 8'hF4
) (
    input  logic              io_wr,
    input  logic [BYTE_W-1:0] io_addr,
    output logic [SEG_CNT-1:0] seg_we,
    output logic              ovr_we
);

    for (genvar g = 0; g < SEG_CNT; g++) begin : g_seg_dec
        localparam logic [BYTE_W-1:0] PORT_ID = SEG_PORT_BASE + BYTE_W'(g);
        assign seg_we[g] = io_wr && (io_addr == PORT_ID);
    end

    assign ovr_we = io_wr && (io_addr == OVR_PORT);

endmodule

// File: rtl/bankmap_regs.sv
module bankmap_regs
    import bankmap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEG_CNT-1:0] seg_we,
    input  logic               ovr_we,
    input  logic [BYTE_W-1:0]  io_data,
    output seg_arr_t           seg_map,
    output logic [SEG_CNT-1:0] ovr_en
);

    typedef struct packed {
        seg_arr_t           seg;
        logic [SEG_CNT-1:0] ovr;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int s = 0; s < SEG_CNT; s++) begin
            if (seg_we[s]) begin
                st_d.seg[s] = decode_byte(io_data);
            end
            if (ovr_we) begin
                st_d.ovr[s] = io_data[override_bit(s)];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.seg <= reset_map();
            st_q.ovr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign seg_map = st_q.seg;
    assign ovr_en  = st_q.ovr;

endmodule

// File: rtl/bankmap_xlate.sv
module bankmap_xlate
    import bankmap_pkg::*;
(
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  seg_arr_t           seg_map,
    input  logic [SEG_CNT-1:0] ovr_en,
    output logic [BANK_W-1:0]  rd_bank,
    output logic [BANK_W-1:0]  wr_bank,
    output logic [OFS_W-1:0]   rd_offset,
    output logic [OFS_W-1:0]   wr_offset
);

    logic [SEL_W-1:0] sel;
    seg_map_t         cur;

    always_comb begin
        sel       = cpu_addr[ADDR_W-1 -: SEL_W];
        cur       = seg_map[sel];
        wr_bank   = cur.wr;
        rd_bank   = ovr_en[sel] ? cur.wr : cur.rd;
        rd_offset = cpu_addr[OFS_W-1:0];
        wr_offset = cpu_addr[OFS_W-1:0];
    end

endmodule

// File: rtl/bankmap_top.sv
module bankmap_top
    import bankmap_pkg::*;
#(
    parameter logic [BYTE_W-1:0] SEG_PORT_BASE = 8'hF0,
    parameter logic [BYTE_W-1:0] OVR_PORT      = 8'hF4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [7:0]        io_addr,
    input  logic [7:0]        io_data,
    input  logic [15:0]       cpu_addr,
    output logic [6:0]        rd_bank,
    output logic [13:0]       rd_offset,
    output logic [6:0]        wr_bank,
    output logic [13:0]       wr_offset
);

    logic [SEG_CNT-1:0] seg_we;
    logic               ovr_we;
    seg_arr_t           seg_map;
    logic [SEG_CNT-1:0] ovr_en;

    bankmap_port_dec #(
        .SEG_PORT_BASE(SEG_PORT_BASE),
        .OVR_PORT     (OVR_PORT)
    ) u_dec (
        .io_wr  (io_wr),
        .io_addr(io_addr),
        .seg_we (seg_we),
        .ovr_we (ovr_we)
    );

    bankmap_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .seg_we (seg_we),
        .ovr_we (ovr_we),
        .io_data(io_data),
        .seg_map(seg_map),
        .ovr_en (ovr_en)
    );

    bankmap_xlate u_xlate (
        .cpu_addr (cpu_addr),
        .seg_map  (seg_map),
        .ovr_en   (ovr_en),
        .rd_bank  (rd_bank),
        .wr_bank  (wr_bank),
        .rd_offset(rd_offset),
        .wr_offset(wr_offset)
    );

endmodule

// File: rtl/bankmap_chk.sv
module bankmap_chk
    import bankmap_pkg::*;
#(
    parameter logic [BYTE_W-1:0] SEG_PORT_BASE = 8'hF0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               io_wr,
    input logic [7:0]         io_addr,
    input logic [7:0]         io_data,
    input logic [15:0]        cpu_addr,
    input logic [6:0]         rd_bank,
    input logic [13:0]        rd_offset,
    input logic [6:0]         wr_bank,
    input logic [13:0]        wr_offset,
    input seg_arr_t           seg_map,
    input logic [SEG_CNT-1:0] ovr_en
);

    logic             seg_port_hit;
    logic [SEL_W-1:0] port_seg;

    assign seg_port_hit = io_wr && (io_addr >= SEG_PORT_BASE)
                        && (io_addr < SEG_PORT_BASE + BYTE_W'(SEG_CNT));
    assign port_seg     = SEL_W'(io_addr - SEG_PORT_BASE);

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_offset == cpu_addr[13:0] && wr_offset == cpu_addr[13:0]);  // R1

    AST_UNIFIED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_port_hit && io_data[7]) |=>
            (cpu_addr[15:14] != $past(port_seg)) ||
            (rd_bank == $past(io_data[6:0]) && wr_bank == $past(io_data[6:0])));  // R2

    AST_SPLIT_WRITE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_port_hit && !io_data[7]) |=>
            (cpu_addr[15:14] != $past(port_seg)) ||
            (wr_bank == {4'b0, $past(io_data[2:0])}));  // R3

    AST_OVERRIDE_COLLAPSE: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_en[cpu_addr[15:14]] |-> rd_bank == wr_bank);  // R5

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr |=> $stable(seg_map) && $stable(ovr_en));  // R7

endmodule

bind bankmap_top bankmap_chk #(.SEG_PORT_BASE(SEG_PORT_BASE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_wr    (io_wr),
    .io_addr  (io_addr),
    .io_data  (io_data),
    .cpu_addr (cpu_addr),
    .rd_bank  (rd_bank),
    .rd_offset(rd_offset),
    .wr_bank  (wr_bank),
    .wr_offset(wr_offset),
    .seg_map  (seg_map),
    .ovr_en   (ovr_en)
);

// File: tb/tb_bankmap_top.sv
module tb_bankmap_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_addr = 8'h00;
    logic [7:0]  io_data = 8'h00;
    logic [15:0] cpu_addr = 16'h0000;
    logic [6:0]  rd_bank, wr_bank;
    logic [13:0] rd_offset, wr_offset;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [6:0]  rd;
        logic [6:0]  wr;
        logic [13:0] ofs;
        string       req;
    } exp_t;

    exp_t exp_q[$];

    // Reference model of the mapping, updated by the driver
    logic [6:0] m_rd[4];
    logic [6:0] m_wr[4];
    logic [7:0] m_ovr;

    always #10 clk = ~clk;

    bankmap_top dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_wr    (io_wr),
        .io_addr  (io_addr),
        .io_data  (io_data),
        .cpu_addr (cpu_addr),
        .rd_bank  (rd_bank),
        .rd_offset(rd_offset),
        .wr_bank  (wr_bank),
        .wr_offset(wr_offset)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] want);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, want);
        end
    endtask

    function automatic int ovr_idx(input int seg);
        case (seg)
            0:       return 6;
            1:       return 4;
            2:       return 5;
            default: return 7;
        endcase
    endfunction

    function automatic logic [6:0] model_rd(input int seg);
        return m_ovr[ovr_idx(seg)] ? m_wr[seg] : m_rd[seg];
    endfunction

    task automatic model_reset();
        for (int s = 0; s < 4; s++) begin
            m_rd[s] = 7'(s);
            m_wr[s] = 7'(s);
        end
        m_ovr = 8'h00;
    endtask

    // Driver: present an address and queue what the mapping should give
    task automatic probe(input logic [15:0] a, input string req);
        exp_t e;
        @(negedge clk);
        cpu_addr = a;
        e.rd  = model_rd(int'(a[15:14]));
        e.wr  = m_wr[a[15:14]];
        e.ofs = a[13:0];
        e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic probe_all(input string req);
        for (int s = 0; s < 4; s++) probe({2'(s), 14'h1A5 + 14'(s * 1111)}, req);
    endtask

    // Port write; the old mapping must still show inside the write cycle (R7)
    task automatic port_write(input logic [7:0] p, input logic [7:0] d);
        @(negedge clk);
        io_wr   = 1'b1;
        io_addr = p;
        io_data = d;
        cpu_addr = {p[1:0], 14'h0};
        #2;
        check("R7 old mapping before edge", {25'b0, wr_bank}, {25'b0, m_wr[p[1:0]]});
        @(negedge clk);
        io_wr = 1'b0;
        if (p >= 8'hF0 && p <= 8'hF3) begin
            if (d[7]) begin
                m_rd[p[1:0]] = d[6:0];
                m_wr[p[1:0]] = d[6:0];
            end else begin
                m_rd[p[1:0]] = {4'b0, d[6:4]};
                m_wr[p[1:0]] = {4'b0, d[2:0]};
            end
        end else if (p == 8'hF4) begin
            m_ovr = d;
        end
    endtask

    // Monitor: compare queued expectations just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.req, " rd_bank"},   {25'b0, rd_bank},   {25'b0, e.rd});
                check({e.req, " wr_bank"},   {25'b0, wr_bank},   {25'b0, e.wr});
                check({e.req, " rd_offset"}, {18'b0, rd_offset}, {18'b0, e.ofs});
                check({e.req, " wr_offset"}, {18'b0, wr_offset}, {18'b0, e.ofs});
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R6 reset mapping, R1 offsets
        probe_all("R6 reset map");
        probe(16'hFFFF, "R1 top offset");
        probe(16'h4000, "R1 window base");

        // R2 unified
        port_write(8'hF1, 8'h85);
        probe(16'h4123, "R2 bank 5 window 1");
        port_write(8'hF3, 8'hFF);
        probe(16'hC000, "R2 bank 127");
        port_write(8'hF3, 8'h87);
        probe(16'hFFFE, "R2 common bank 7");

        // R3 split, bit 3 ignored
        port_write(8'hF0, 8'h53);
        probe(16'h0010, "R3 split 5/3");
        port_write(8'hF2, 8'h7A);
        probe(16'h8F00, "R3 split bit3 ignored");
        port_write(8'hF1, 8'h05);
        probe(16'h7FFF, "R3 bit7 clear vs 0x85");

        // R4 other ports change nothing
        port_write(8'hF5, 8'h81);
        port_write(8'hEF, 8'h82);
        port_write(8'h70, 8'h83);
        probe_all("R4 stray ports");

        // R7 strobe low leaves mapping alone
        @(negedge clk);
        io_addr = 8'hF0;
        io_data = 8'h99;
        repeat (2) @(negedge clk);
        probe_all("R7 no strobe");

        // R5 per-window override with distinct split mappings
        port_write(8'hF0, 8'h61);
        port_write(8'hF1, 8'h72);
        port_write(8'hF2, 8'h43);
        port_write(8'hF3, 8'h54);
        probe_all("R5 no override");
        for (int b = 4; b < 8; b++) begin
            port_write(8'hF4, 8'(1 << b));
            probe_all($sformatf("R5 override bit %0d", b));
        end
        port_write(8'hF4, 8'h0F);
        probe_all("R5 low nibble ignored");
        port_write(8'hF4, 8'hF0);
        probe_all("R5 all override");

        // R6 reset again restores mapping and clears override
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        probe_all("R6 reset after use");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule